// File: doc/BRIEF.md
# Port Clock-Output Multiplexer

This block owns an 8-bit output port and decides, pin by pin, whether each pin shows a value written by software or a clock. Two of the pins can each run as a divide-by-two of a timer: every single-cycle overflow pulse from the matching timer flips the pin. A third pin can carry a baud-rate clock straight through, without registering it. The remaining pins always follow the stored port value. When a clock output is switched off, its pin goes back to the stored port bit without a stray pulse.

Software reaches three byte registers through a plain address, write-enable and data bus:
- The port value register (`0x04`).
- The direction register (`0x0C`), which is driven out as per-pin output enables.
- The control register (`0x0F`). Its low three bits select the clock outputs. Its upper five bits are stored for other logic and have no effect here.

The bus has no back-pressure. A write is taken on every rising edge that sees `bus_wr` high. The read data is a combinational view of the addressed register.

Top module: `port_clkout_mux`

## Requirements
- R1: After reset the port value register reads 0xFF, the direction register reads 0x00, the control register reads 0x80, `pin_out` is 0xFF and `pin_dir` is 0x00.
- R2: A write at address 0x04, 0x0C or 0x0F stores the whole byte, and reading that address returns it. Any other address reads 0x00, and a write to it changes no register.
- R3: Control bit 0 selects the clock output on pin 0, driven by `ovf_pulse[0]`. Control bit 1 selects it on pin 1, driven by `ovf_pulse[1]`. A pulse for one lane never moves the other lane's pin.
- R4: After a clock output is enabled, its pin first shows the stored port bit. From the first rising edge after the enabling write, each overflow pulse sampled on a rising edge inverts the pin after that edge.
- R5: While a clock output is enabled and no overflow pulse arrives, its pin holds its level.
- R6: One cycle after a write that clears an enable bit, the pin equals its stored port bit. Overflow pulses arriving while the bit is clear leave the pin unchanged.
- R7: While control bit 2 is set, pin 2 follows `baud_clk` combinationally. While it is clear, pin 2 shows stored port bit 2.
- R8: Pins 3 to 7 always show their stored port bits. A write to the port value register while a clock output runs is stored and read back, but does not change the toggling pin.
- R9: Control bits 7 to 3 are stored and read back and have no effect on any pin.
- R10: `pin_dir` always equals the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address for writes and reads |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| ovf_pulse | input | 2 | Single-cycle timer overflow pulses, one per toggling lane |
| baud_clk | input | 1 | Baud-rate clock passed to pin 2 |
| pin_out | output | 8 | Port pin levels |
| pin_dir | output | 8 | Per-pin output enables from the direction register |

## Verification
If a toggle flip-flop held the wrong value, its pin would show the wrong level. That shows up on the first rising edge after the enable takes effect, and again after every overflow pulse, because the error persists until the lane is disabled.

If the enable-history register were stuck, a disabled pin would keep its stale toggle level one cycle after the clearing write, instead of returning to the port bit.

A register-decode fault shows up at once on `bus_rdata`. It also appears on `pin_out` or `pin_dir` in the cycle after the wrong write.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int unsigned PCM_DW      = 8;
  localparam int unsigned PCM_AW      = 8;
  localparam int unsigned PCM_NUM_TOG = 2;
  localparam int unsigned PCM_BAUD_BIT = 2;

  localparam logic [PCM_AW-1:0] PCM_ADDR_LATCH = 8'h04;
  localparam logic [PCM_AW-1:0] PCM_ADDR_DIR   = 8'h0C;
  localparam logic [PCM_AW-1:0] PCM_ADDR_MISC  = 8'h0F;

  localparam logic [PCM_DW-1:0] PCM_RST_LATCH = 8'hFF;
  localparam logic [PCM_DW-1:0] PCM_RST_DIR   = 8'h00;
  localparam logic [PCM_DW-1:0] PCM_RST_MISC  = 8'h80;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_MISC  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pcm_regfile.sv
module pcm_regfile
  import pcm_pkg::*;
#(
  parameter int unsigned DW = PCM_DW,
  parameter int unsigned AW = PCM_AW,
  parameter int unsigned EN_W = PCM_BAUD_BIT + 1,
  parameter logic [AW-1:0] ADDR_LATCH = PCM_ADDR_LATCH,
  parameter logic [AW-1:0] ADDR_DIR   = PCM_ADDR_DIR,
  parameter logic [AW-1:0] ADDR_MISC  = PCM_ADDR_MISC,
  parameter logic [DW-1:0] RST_LATCH  = PCM_RST_LATCH,
  parameter logic [DW-1:0] RST_DIR    = PCM_RST_DIR,
  parameter logic [DW-1:0] RST_MISC   = PCM_RST_MISC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] latch_q,
  output logic [DW-1:0] dir_q,
  output logic [EN_W-1:0] clk_en
);
  logic [DW-1:0] misc_q;
  reg_sel_e sel;

  always_comb begin
    if (bus_addr == ADDR_LATCH)      sel = SEL_LATCH;
    else if (bus_addr == ADDR_DIR)   sel = SEL_DIR;
    else if (bus_addr == ADDR_MISC)  sel = SEL_MISC;
    else                             sel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= RST_LATCH;
      dir_q   <= RST_DIR;
      misc_q  <= RST_MISC;
    end else if (bus_wr) begin
      case (sel)
        SEL_LATCH: latch_q <= bus_wdata;
        SEL_DIR:   dir_q   <= bus_wdata;
        SEL_MISC:  misc_q  <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_LATCH: bus_rdata = latch_q;
      SEL_DIR:   bus_rdata = dir_q;
      SEL_MISC:  bus_rdata = misc_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign clk_en = misc_q[EN_W-1:0];

  // R2
  latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_LATCH) |=> latch_q == $past(bus_wdata));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr) |=> ($stable(latch_q) && $stable(dir_q) && $stable(misc_q)));
endmodule

// File: rtl/pcm_toggle_lane.sv
module pcm_toggle_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ovf,
  input  logic latch_bit,
  output logic pin
);
  logic en_q;
  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      en_q <= en;
      if (en && !en_q)
        tog_q <= latch_bit ^ ovf;
      else if (en && ovf)
        tog_q <= ~tog_q;
    end
  end

  assign pin = en_q ? tog_q : latch_bit;

  // R4
  toggle_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_q && ovf) |=> (pin != $past(pin)));

  // R5
  hold_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_q && !ovf) |=> $stable(pin));
endmodule

// File: rtl/port_clkout_mux.sv
module port_clkout_mux
  import pcm_pkg::*;
#(
  parameter int unsigned DW       = PCM_DW,
  parameter int unsigned AW       = PCM_AW,
  parameter int unsigned NUM_TOG  = PCM_NUM_TOG,
  parameter int unsigned BAUD_BIT = PCM_BAUD_BIT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NUM_TOG-1:0] ovf_pulse,
  input  logic               baud_clk,
  output logic [DW-1:0]      pin_out,
  output logic [DW-1:0]      pin_dir
);
  localparam int unsigned EN_W = BAUD_BIT + 1;

  logic [DW-1:0]   latch_q;
  logic [DW-1:0]   dir_q;
  logic [EN_W-1:0] clk_en;

  pcm_regfile #(
    .DW(DW), .AW(AW), .EN_W(EN_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .latch_q(latch_q), .dir_q(dir_q), .clk_en(clk_en)
  );

  assign pin_dir = dir_q;

  for (genvar i = 0; i < NUM_TOG; i++) begin : g_tog
    logic lane_pin;
    pcm_toggle_lane u_lane (
      .clk(clk), .rst_n(rst_n),
      .en(clk_en[i]), .ovf(ovf_pulse[i]),
      .latch_bit(latch_q[i]), .pin(lane_pin)
    );
    assign pin_out[i] = lane_pin;

    // R6
    release_to_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en[i]) |=> (pin_out[i] == latch_q[i]));
  end

  for (genvar j = NUM_TOG; j < DW; j++) begin : g_plain
    if (j == BAUD_BIT) begin : g_baud
      assign pin_out[j] = clk_en[BAUD_BIT] ? baud_clk : latch_q[j];
    end else begin : g_latch
      assign pin_out[j] = latch_q[j];
    end
  end

  // R3
  lane_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en[0] && $past(clk_en[0]) && !ovf_pulse[0] && ovf_pulse[1])
      |=> $stable(pin_out[0]));
endmodule

// File: tb/tb_port_clkout_mux.sv
`timescale 1ns/1ps
module tb_port_clkout_mux;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] ovf_pulse = 2'b00;
  logic       baud_clk = 1'b0;
  logic [7:0] pin_out;
  logic [7:0] pin_dir;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  port_clkout_mux dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_pulse(ovf_pulse),
    .baud_clk(baud_clk), .pin_out(pin_out), .pin_dir(pin_dir)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [1:0] m);
    @(negedge clk);
    ovf_pulse = m;
    @(negedge clk);
    ovf_pulse = 2'b00;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_check("R1 latch", 8'h04, 8'hFF);
    rd_check("R1 dir", 8'h0C, 8'h00);
    rd_check("R1 misc", 8'h0F, 8'h80);
    check("R1 pins", pin_out, 8'hFF);
    check("R1 pin_dir", pin_dir, 8'h00);
  endtask

  task automatic t_regs;
    wr(8'h0C, 8'hA5);
    rd_check("R2 dir readback", 8'h0C, 8'hA5);
    check("R10 pin_dir", pin_dir, 8'hA5);
    wr(8'h04, 8'h3C);
    rd_check("R2 latch readback", 8'h04, 8'h3C);
    check("R8 pins follow latch", pin_out, 8'h3C);
    wr(8'h05, 8'h00);
    rd_check("R2 unmapped read", 8'h05, 8'h00);
    rd_check("R2 unmapped write", 8'h04, 8'h3C);
    wr(8'h0F, 8'hF8);
    rd_check("R9 misc readback", 8'h0F, 8'hF8);
    pulse(2'b11);
    check("R9 upper bits no effect", pin_out, 8'h3C);
    wr(8'h0F, 8'h00);
  endtask

  task automatic t_lane0;
    wr(8'h0F, 8'h01);
    check("R4 start at latch", pin_out, 8'h3C);
    idle(3);
    check("R5 hold", pin_out, 8'h3C);
    pulse(2'b01);
    check("R4 first toggle", pin_out, 8'h3D);
    pulse(2'b10);
    check("R3 lane1 pulse ignored", pin_out, 8'h3D);
    pulse(2'b01);
    check("R4 second toggle", pin_out, 8'h3C);
    pulse(2'b01);
    check("R4 third toggle", pin_out, 8'h3D);
    wr(8'h04, 8'hC2);
    rd_check("R8 latch stored", 8'h04, 8'hC2);
    check("R8 toggle undisturbed", pin_out, 8'hC3);
    wr(8'h0F, 8'h00);
    idle(1);
    check("R6 back to latch", pin_out, 8'hC2);
    pulse(2'b01);
    check("R6 pulse ignored", pin_out, 8'hC2);
  endtask

  task automatic t_lane1;
    wr(8'h0F, 8'h02);
    check("R4 lane1 start", pin_out, 8'hC2);
    pulse(2'b10);
    check("R3 lane1 toggle", pin_out, 8'hC0);
    pulse(2'b01);
    check("R3 lane0 pulse ignored", pin_out, 8'hC0);
    wr(8'h0F, 8'h00);
    idle(1);
    check("R6 lane1 release", pin_out, 8'hC2);
  endtask

  task automatic t_both;
    wr(8'h04, 8'h00);
    wr(8'h0F, 8'h03);
    pulse(2'b11);
    check("R3 both toggle", pin_out, 8'h03);
    pulse(2'b01);
    check("R3 lane0 only", pin_out, 8'h02);
    wr(8'h0F, 8'h00);
    idle(1);
    check("R6 both release", pin_out, 8'h00);
  endtask

  task automatic t_baud;
    wr(8'h04, 8'h04);
    baud_clk = 1'b0;
    wr(8'h0F, 8'h04);
    check("R7 baud low", pin_out, 8'h00);
    baud_clk = 1'b1; #1;
    check("R7 baud high", pin_out, 8'h04);
    baud_clk = 1'b0; #1;
    check("R7 baud low again", pin_out, 8'h00);
    wr(8'h0F, 8'h00);
    check("R7 back to latch", pin_out, 8'h04);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(2);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_regs();
    t_lane0();
    t_lane1();
    t_both();
    t_baud();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule